// File: doc/BRIEF.md
# No-Wait-State Pipelined Synchronous SRAM

This block is a single-clock synchronous static RAM whose read and write cycles share one pipeline depth. A command is registered on one rising edge. Its data moves on the second enabled rising edge after that: a read presents its word at that edge, and a write captures its word at that edge. Because reads and writes take the same number of stages, any mix of the two can be issued on consecutive cycles with no idle cycle between them.

Commands come from an advance/load control. With advance low, the block loads a new address and starts a read, write or deselect cycle, depending on the read/write select and three chip enables. With advance high, a two-bit burst counter steps through the aligned group of four words in linear or interleaved order, and the cycle type stays the same. The write uses per-byte enables. A clock enable can freeze the whole block for any number of cycles. The shared data bus is modelled as separate input and output vectors and an output enable. The default array is 256 words of 36 bits in four 9-bit byte lanes.

Top module: `nws_sram`

## Requirements
- R1: A read command is sampled at enabled edge k. After enabled edge k+2, `dout` holds the stored word and `dout_oe` is 1.
- R2: For a write command sampled at enabled edge k, the word on `din` is captured at enabled edge k+2 and stored.
- R3: Reads and writes, to the same or different addresses, may be issued on consecutive enabled edges with no idle cycle. Each read returns the contents left by all writes issued before it.
- R4: Bit i of `bw_n`, when low, enables byte lane i, which is bits [9i+8:9i]. A write changes only the enabled lanes and leaves the others as they were. The byte enables are sampled along with each command or burst beat.
- R5: While `clk_en_n` is 1, every input is ignored and all state holds, including `dout` and `dout_oe`. A suspended edge does not count as a pipeline step.
- R6: With `adv` low, `addr` is loaded and a new cycle starts. With `adv` high, the burst counter advances and the previous cycle type continues. During that time `we_n`, `addr`, `burst_ilv` and the chip enables are ignored. A burst that continues a deselect stays deselected.
- R7: With `burst_ilv` low at load, beat c of a burst uses a low address pair equal to (base + c) mod 4. The upper address bits stay fixed.
- R8: With `burst_ilv` high at load, beat c uses a low address pair equal to base XOR c.
- R9: A load cycle is a deselect unless `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A deselect writes nothing, and two enabled edges later `dout_oe` is 0.
- R10: `dout_oe` is 0 during the data phase of a write.
- R11: After reset, `dout_oe` and `dout` are 0 and the pipeline holds no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Clock enable, low to run, high to suspend |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | High: advance burst; low: load new command |
| we_n | input | 1 | Low: write, high: read (on load) |
| bw_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order on load: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| din | input | DW | Write data bus side |
| dout | output | DW | Read data bus side |
| dout_oe | output | 1 | High when `dout` should drive the bus |

## Verification
Each result is due on the second enabled rising edge after its command. Read data and the output enable appear then, and write data is captured then. Suspended edges shift nothing. The bench drives inputs on falling edges and checks outputs on the next falling edge. It keeps a two-entry model pipeline that advances only on unsuspended edges, so every check looks at the exact cycle in which the value is due. A reference array applies each masked write at the edge where its data is captured, and reads are compared against that array.

// File: rtl/nws_pkg.sv
package nws_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address pair for a burst beat
  function automatic logic [1:0] burst_ofs(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    logic [1:0] sum;
    sum = base + cnt;
    return ilv ? (base ^ cnt) : sum;
  endfunction

endpackage

// File: rtl/nws_burst.sv
module nws_burst
  import nws_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             adv,
  input  logic             sel,
  input  logic             we_n,
  input  logic             ilv,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] be_o
);

  localparam int BB = 2;

  op_e              op_q,   op_d;
  logic [AW-1:0]    base_q, base_d;
  logic [BB-1:0]    cnt_q,  cnt_d;
  logic             ilv_q,  ilv_d;
  logic [LANES-1:0] be_q,   be_d;

  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    ilv_d  = ilv_q;
    be_d   = be_q;
    if (en) begin
      be_d = ~bw_n;
      if (!adv) begin
        base_d = addr;
        cnt_d  = '0;
        ilv_d  = ilv;
        if (!sel)      op_d = OP_IDLE;
        else if (we_n) op_d = OP_RD;
        else           op_d = OP_WR;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
      be_q   <= '0;
    end else begin
      op_q   <= op_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ilv_q  <= ilv_d;
      be_q   <= be_d;
    end
  end

  assign op_o   = op_q;
  assign be_o   = be_q;
  assign addr_o = {base_q[AW-1:BB], burst_ofs(base_q[BB-1:0], cnt_q, ilv_q)};

endmodule

// File: rtl/nws_array.sv
module nws_array #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                we,
  input  logic [LANES-1:0]    be,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[l]) mem[addr] <= wdata[l*LW +: LW];
    end

    assign rdata[l*LW +: LW] = mem[addr];
  end

endmodule

// File: rtl/nws_sram.sv
module nws_sram
  import nws_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             adv,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);

  logic             en;
  logic             sel;
  op_e              s0_op;
  logic [AW-1:0]    s0_addr;
  logic [LANES-1:0] s0_be;

  op_e              s1_op_q,   s1_op_d;
  logic [AW-1:0]    s1_addr_q, s1_addr_d;
  logic [LANES-1:0] s1_be_q,   s1_be_d;

  logic [DW-1:0]    dout_q, dout_d;
  logic             oe_q,   oe_d;
  logic [DW-1:0]    rdata;
  logic             arr_we;

  assign en  = ~clk_en_n;
  assign sel = ~cs0_n & cs1 & ~cs2_n;

  // stage 0: command and burst address
  nws_burst #(.AW(AW), .LANES(LANES)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .adv    (adv),
    .sel    (sel),
    .we_n   (we_n),
    .ilv    (burst_ilv),
    .bw_n   (bw_n),
    .addr   (addr),
    .op_o   (s0_op),
    .addr_o (s0_addr),
    .be_o   (s0_be)
  );

  // stage 1 next state
  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_be_d   = s1_be_q;
    if (en) begin
      s1_op_d   = s0_op;
      s1_addr_d = s0_addr;
      s1_be_d   = s0_be;
    end
  end

  // stage 2: data phase
  assign arr_we = en && (s1_op_q == OP_WR);

  nws_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .be    (s1_be_q),
    .addr  (s1_addr_q),
    .wdata (din),
    .rdata (rdata)
  );

  always_comb begin
    dout_d = dout_q;
    oe_d   = oe_q;
    if (en) begin
      oe_d = (s1_op_q == OP_RD);
      if (s1_op_q == OP_RD) dout_d = rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s1_be_q   <= '0;
      dout_q    <= '0;
      oe_q      <= 1'b0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_be_q   <= s1_be_d;
      dout_q    <= dout_d;
      oe_q      <= oe_d;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

endmodule

// File: rtl/nws_sram_chk.sv
module nws_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          adv,
  input logic          we_n,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);

  logic ld_sel;
  assign ld_sel = !clk_en_n && !adv && !cs0_n && cs1 && !cs2_n;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel && we_n) ##1 !clk_en_n ##1 !clk_en_n |=> dout_oe);  // R1

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(dout) && $stable(dout_oe)));  // R5

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && (cs0_n || !cs1 || cs2_n)) ##1 !clk_en_n ##1 !clk_en_n
    |=> !dout_oe);  // R9

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel && !we_n) ##1 !clk_en_n ##1 !clk_en_n |=> !dout_oe);  // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dout_oe && (dout == '0)));  // R11

endmodule

bind nws_sram nws_sram_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .cs0_n    (cs0_n),
  .cs1      (cs1),
  .cs2_n    (cs2_n),
  .adv      (adv),
  .we_n     (we_n),
  .dout     (dout),
  .dout_oe  (dout_oe)
);

// File: tb/test_nws_sram.sv
module test_nws_sram;

  localparam int AW    = 8;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam logic [2:0] CS_ON = 3'b010;  // {cs2_n, cs1, cs0_n}
  localparam logic [DW-1:0] JUNK = 36'hA5A5A5A5A;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             clk_en_n, cs0_n, cs1, cs2_n, adv, we_n, burst_ilv;
  logic [LANES-1:0] bw_n;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    din, dout;
  logic             dout_oe;

  always #2.5 clk = ~clk;

  nws_sram #(.AW(AW), .LANES(LANES), .LW(LW)) i_nws_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "";

  logic [DW-1:0] ref_mem [1 << AW];

  // model: burst state and two-entry pipeline
  int            m_op;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_ilv;
  int            n_op, o_op;
  logic [AW-1:0] n_addr, o_addr;
  logic [LANES-1:0] n_be, o_be;
  logic [DW-1:0] n_dat, o_dat;
  logic          exp_oe;
  logic [DW-1:0] exp_dout;

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input logic ck_n, input logic a_dv, input logic w_n,
                      input logic [2:0] csv, input logic [LANES-1:0] bwn,
                      input logic [AW-1:0] ad, input logic md, input logic [DW-1:0] wd);
    logic [1:0] lo;
    clk_en_n = ck_n; adv = a_dv; we_n = w_n;
    cs0_n = csv[0]; cs1 = csv[1]; cs2_n = csv[2];
    bw_n = bwn; addr = ad; burst_ilv = md;
    din = (!ck_n && o_op == 2) ? o_dat : JUNK;
    @(posedge clk);
    #1;
    if (!ck_n) begin
      if (o_op == 2)
        for (int l = 0; l < LANES; l++)
          if (o_be[l]) ref_mem[o_addr][l*LW +: LW] = o_dat[l*LW +: LW];
      exp_oe = (o_op == 1);
      if (o_op == 1) exp_dout = ref_mem[o_addr];
      o_op = n_op; o_addr = n_addr; o_be = n_be; o_dat = n_dat;
      if (!a_dv) begin
        m_base = ad; m_cnt = 2'd0; m_ilv = md;
        if (!(!csv[0] && csv[1] && !csv[2])) m_op = 0;
        else m_op = w_n ? 1 : 2;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      n_op = m_op; n_addr = {m_base[AW-1:2], lo}; n_be = ~bwn; n_dat = wd;
    end
    @(negedge clk);
    chk("dout_oe", {{(DW-1){1'b0}}, dout_oe}, {{(DW-1){1'b0}}, exp_oe});
    if (exp_oe) chk("dout", dout, exp_dout);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LANES-1:0] bwn);
    step(1'b0, 1'b0, 1'b0, CS_ON, bwn, a, 1'b0, d);
  endtask
  task automatic rd(input logic [AW-1:0] a, input logic md);
    step(1'b0, 1'b0, 1'b1, CS_ON, '1, a, md, JUNK);
  endtask
  // burst beat with ignored we_n, chip enables, address and mode
  task automatic beat(input logic [DW-1:0] d);
    step(1'b0, 1'b1, 1'b1, 3'b101, '0, 8'hEE, 1'b1, d);
  endtask
  task automatic nop();
    step(1'b0, 1'b0, 1'b1, 3'b011, '1, 8'h00, 1'b0, JUNK);
  endtask
  task automatic hold();
    step(1'b1, 1'b0, 1'b0, CS_ON, '0, 8'h77, 1'b1, JUNK);
  endtask
  task automatic drain();
    nop(); nop();
  endtask

  task automatic t_reset();
    cur_req = "R11";
    chk("reset dout_oe", {{(DW-1){1'b0}}, dout_oe}, '0);
    chk("reset dout", dout, '0);
    nop();
    chk("idle dout_oe", {{(DW-1){1'b0}}, dout_oe}, '0);
  endtask

  task automatic t_basic();
    cur_req = "R1 R2";
    wr(8'h05, 36'h123456789, '0);
    wr(8'h06, 36'hFEDCBA987, '0);
    wr(8'h77, 36'h0F0F0F0F0, '0);
    wr(8'hEE, 36'h3C3C3C3C3, '0);
    drain();
    rd(8'h05, 1'b0); rd(8'h06, 1'b0); rd(8'h77, 1'b0); rd(8'hEE, 1'b0);
    drain();
  endtask

  task automatic t_mixed();
    cur_req = "R3 R10";
    wr(8'h20, 36'h111111111, '0);
    rd(8'h20, 1'b0);
    wr(8'h21, 36'h222222222, '0);
    rd(8'h05, 1'b0);
    rd(8'h21, 1'b0);
    wr(8'h20, 36'h333333333, '0);
    rd(8'h20, 1'b0);
    rd(8'h20, 1'b0);
    wr(8'h20, 36'h444444444, '0);
    drain();
    rd(8'h20, 1'b0);
    drain();
  endtask

  task automatic t_bytes();
    cur_req = "R4";
    wr(8'h30, 36'h000000000, '0);
    wr(8'h30, 36'hFFFFFFFFF, 4'b1010);
    rd(8'h30, 1'b0);
    wr(8'h30, 36'h1AB2CD3EF, 4'b0111);
    rd(8'h30, 1'b0);
    drain();
  endtask

  task automatic t_linear();
    cur_req = "R6 R7";
    wr(8'h42, 36'h0000000A2, '0);
    beat(36'h0000000A3);
    beat(36'h0000000A0);
    beat(36'h0000000A1);
    rd(8'h40, 1'b0);
    beat(JUNK); beat(JUNK); beat(JUNK);
    drain();
    rd(8'h43, 1'b0);
    beat(JUNK);
    drain();
  endtask

  task automatic t_ilv();
    cur_req = "R8";
    rd(8'h41, 1'b1);
    beat(JUNK); beat(JUNK); beat(JUNK);
    step(1'b0, 1'b0, 1'b0, CS_ON, '0, 8'h53, 1'b1, 36'h000000B3);
    beat(36'h0000000B2); beat(36'h0000000B1); beat(36'h0000000B0);
    rd(8'h50, 1'b0);
    beat(JUNK); beat(JUNK); beat(JUNK);
    drain();
  endtask

  task automatic t_suspend();
    cur_req = "R5";
    wr(8'h60, 36'h600000060, '0);
    hold(); hold();
    rd(8'h60, 1'b0);
    hold();
    nop();
    hold(); hold();
    nop();
    rd(8'h77, 1'b0);
    drain();
  endtask

  task automatic t_deselect();
    cur_req = "R9";
    wr(8'h70, 36'h707070707, '0);
    drain();
    step(1'b0, 1'b0, 1'b0, 3'b011, '0, 8'h70, 1'b0, JUNK);
    step(1'b0, 1'b0, 1'b0, 3'b000, '0, 8'h70, 1'b0, JUNK);
    step(1'b0, 1'b0, 1'b0, 3'b110, '0, 8'h70, 1'b0, JUNK);
    step(1'b0, 1'b1, 1'b0, CS_ON, '0, 8'h70, 1'b0, JUNK);
    drain();
    rd(8'h70, 1'b0);
    rd(8'h71, 1'b0);
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clk_en_n = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    adv = 1'b0; we_n = 1'b1; bw_n = '1; burst_ilv = 1'b0;
    addr = '0; din = '0;
    m_op = 0; m_base = '0; m_cnt = '0; m_ilv = 1'b0;
    n_op = 0; o_op = 0; n_addr = '0; o_addr = '0; n_be = '0; o_be = '0;
    n_dat = '0; o_dat = '0; exp_oe = 1'b0; exp_dout = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mixed();
    t_bytes();
    t_linear();
    t_ilv();
    t_suspend();
    t_deselect();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule